// File: doc/BRIEF.md
# Cascadable 512 x 9 FIFO with Active-Low Flags

This block is a first-in first-out buffer of 512 nine-bit words. Producers and consumers use active-low strobes: `wr_n` for writes and `rd_n` for reads. The block samples both strobes on one system clock and acts on their edges. A write is committed when `wr_n` returns high. A read begins when `rd_n` goes low; the oldest word is then driven on `dout`, and `dout_oe` stays asserted until the strobe is released. A master reset empties the buffer. Three active-low flags report the fill level: empty, half full and full.

Several copies can be chained into one deeper buffer. Each copy holds a write token and a read token, and it acts on a strobe only while it holds the matching token. When a copy writes or reads its last physical location, it hands the token onward with a one-cycle low pulse. The next copy in the ring takes that pulse on its grant input. Chained copies share `din`, `wr_n` and `rd_n`, and `dout_oe` tells which copy owns the shared output. With `EXPAND_EN` set to 0 the copy works alone and holds both tokens permanently.

Top module: `cascade_fifo`

## Requirements
- R1: Words leave in the order they were accepted, each unchanged in all 9 bits, with up to 512 words stored.
- R2: While `rst_n` is low and on the cycle after it, `empty_n` is 0, `half_n` is 1, `full_n` is 1 and `dout_oe` is 0. Both strobes are held high around reset.
- R3: A write stores the value on `din` in the clock cycle in which a high level of `wr_n` is first seen after a low one. A falling `wr_n` with no return to high stores nothing.
- R4: In the clock cycle in which a low `rd_n` is first seen, an accepted read puts the oldest word on `dout` and drives `dout_oe` to 1. `dout_oe` returns to 0 in the cycle after `rd_n` is seen high.
- R5: A read started while the buffer is empty leaves `dout_oe` at 0 and changes no flag.
- R6: `empty_n` rises after the first write into an empty buffer and falls when the last stored word is read.
- R7: `half_n` is 0 exactly when the occupancy is at least 256: it falls on the write that reaches 256 and rises on the read that drops below it.
- R8: `full_n` is 0 exactly when 512 words are stored. A write while it is 0 is discarded, and any read from a full buffer raises it.
- R9: The read and write positions wrap from location 511 back to 0 with no gap, so a word written after a wrap leaves in the correct order.
- R10: A write commit and a read start in the same cycle, with the buffer neither empty nor full, leave the occupancy unchanged.
- R11: Writing location 511 pulses `wx_out_n` low for exactly one cycle. In chained mode it also gives up the write token. A device with `LEAD`=1 holds both tokens after reset; any other device gets the write token from a low pulse on `wx_in_n`, and without the token it ignores writes.
- R12: Reading location 511 pulses `rx_out_n` low for exactly one cycle and, in chained mode, gives up the read token. A device without the read token leaves `dout_oe` at 0 even when it holds data; a low pulse on `rx_in_n` grants the token.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| din | input | 9 | Write data |
| dout | output | 9 | Read data, valid while `dout_oe` is 1 |
| dout_oe | output | 1 | Output-enable indication for `dout` |
| empty_n | output | 1 | Low when no word is stored |
| half_n | output | 1 | Low when at least half the depth is occupied |
| full_n | output | 1 | Low when every location is occupied |
| wx_in_n | input | 1 | Write-token grant pulse from the previous device |
| wx_out_n | output | 1 | Write-token hand-off pulse to the next device |
| rx_in_n | input | 1 | Read-token grant pulse from the previous device |
| rx_out_n | output | 1 | Read-token hand-off pulse to the next device |

## Verification
The bench targets several corner cases:
- A strobe held low with no release. A design that commits on the falling edge would raise `empty_n` too early.
- A read from an empty buffer. A design that misses this would assert `dout_oe` and move the read position into stale data.
- The exact occupancies 255/256 and 511/512, including a write while full. An off-by-one threshold would move a flag one word early or late, and a missing full guard would overwrite the oldest word.
- A write after both positions have wrapped, and a simultaneous read and write at occupancy 1. A faulty wrap would reorder the data, and faulty simultaneous accounting would report empty while a word is still held.
- In the chained pair, the second device holds free space and data but no token for the first 512 operations. A design that ignores token ownership would accept those writes or drive the shared output out of turn.

// File: rtl/cfifo_pkg.sv
// Shared types for the cascadable FIFO.
// Assumes: all consumers run in the single system clock domain.
package cfifo_pkg;

    // Strobe events decoded from the sampled active-low strobes.
    typedef struct packed {
        logic wr_done;   // write strobe released: commit point
        logic rd_begin;  // read strobe asserted: read start point
        logic rd_idle;   // read strobe currently high
    } strobe_ev_t;

endpackage

// File: rtl/cfifo_strobe.sv
// Turns the active-low strobes into single-cycle events.
// Assumes: strobes are already synchronous to clk and are high during reset.
module cfifo_strobe
    import cfifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_n,
    input  logic       rd_n,
    output strobe_ev_t ev
);

    logic wr_q;
    logic rd_q;

    // Keep the previous strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b1;
            rd_q <= 1'b1;
        end else begin
            wr_q <= wr_n;
            rd_q <= rd_n;
        end
    end

    // Decode the edges against the stored levels.
    always_comb begin
        ev.wr_done  = wr_n & ~wr_q;
        ev.rd_begin = ~rd_n & rd_q;
        ev.rd_idle  = rd_n;
    end

endmodule

// File: rtl/cfifo_token.sv
// Ownership of one direction (write or read) in a chain of FIFOs.
// Variant chosen by EXPAND_EN: chained (token passed around a ring) or
// standalone (token always held). Both variants emit a one-cycle low
// pulse when the last physical location is used.
// Assumes: op_go is only asserted while hold is 1.
module cfifo_token #(
    parameter bit EXPAND_EN = 1'b1,
    parameter bit LEAD      = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic op_go,
    input  logic at_last,
    input  logic grant_n,
    output logic hold,
    output logic pass_n
);

    logic pass_q;

    // Register the hand-off pulse so it lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pass_q <= 1'b1;
        else        pass_q <= ~(op_go & at_last);
    end

    assign pass_n = pass_q;

    generate
        if (EXPAND_EN) begin : g_chain
            logic hold_q;

            // Drop the token after the last location; take it on a grant pulse.
            always_ff @(posedge clk) begin
                if (!rst_n)                hold_q <= LEAD;
                else if (op_go && at_last) hold_q <= 1'b0;
                else if (!grant_n)         hold_q <= 1'b1;
            end

            assign hold = hold_q;
        end else begin : g_solo
            logic unused_solo;
            assign unused_solo = grant_n ^ LEAD;
            assign hold = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/cfifo_store.sv
// Dual-port word storage with independent wrapping write and read pointers.
// Assumes: callers never write when full nor read when empty.
module cfifo_store #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic              rd_go,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_word,
    output logic              w_last,
    output logic              r_last
);

    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr;
    logic [AW-1:0]     rptr;

    // Write port: store the incoming word at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_go) mem[wptr] <= din;
    end

    // Advance both pointers with wrap at the last location.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_go) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (rd_go) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
        end
    end

    assign rd_word = mem[rptr];
    assign w_last  = (wptr == LAST);
    assign r_last  = (rptr == LAST);

endmodule

// File: rtl/cfifo_flags.sv
// Occupancy counter and registered active-low status flags.
// Assumes: wr_go is gated by full_n and rd_go by empty_n.
module cfifo_flags #(
    parameter int DEPTH = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_go,
    input  logic rd_go,
    output logic empty_n,
    output logic half_n,
    output logic full_n
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

    logic [CW-1:0] occ_q;
    logic [CW-1:0] occ_d;

    // Next occupancy: a simultaneous write and read cancel out.
    always_comb begin
        unique case ({wr_go, rd_go})
            2'b10:   occ_d = occ_q + 1'b1;
            2'b01:   occ_d = occ_q - 1'b1;
            default: occ_d = occ_q;
        endcase
    end

    // Register the occupancy and flags derived from its next value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q   <= '0;
            empty_n <= 1'b0;
            half_n  <= 1'b1;
            full_n  <= 1'b1;
        end else begin
            occ_q   <= occ_d;
            empty_n <= (occ_d != '0);
            half_n  <= (occ_d < HALF_C);
            full_n  <= (occ_d != FULL_C);
        end
    end

endmodule

// File: rtl/cascade_fifo.sv
// Cascadable FIFO top: strobe decode, token ownership, storage, flags
// and the registered output stage with its output-enable indication.
// Assumes: one clock domain; strobes are held high around reset; in a
// chain all devices share din, wr_n and rd_n and form rings on the
// wx/rx token pins.
module cascade_fifo
    import cfifo_pkg::*;
#(
    parameter int DATA_W    = 9,
    parameter int DEPTH     = 512,
    parameter bit EXPAND_EN = 1'b1,
    parameter bit LEAD      = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              empty_n,
    output logic              half_n,
    output logic              full_n,
    input  logic              wx_in_n,
    output logic              wx_out_n,
    input  logic              rx_in_n,
    output logic              rx_out_n
);

    strobe_ev_t        ev;
    logic              w_hold;
    logic              r_hold;
    logic              w_last;
    logic              r_last;
    logic              wr_go;
    logic              rd_go;
    logic [DATA_W-1:0] rd_word;

    cfifo_strobe u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_n  (wr_n),
        .rd_n  (rd_n),
        .ev    (ev)
    );

    // Accept an operation only with the token and room or data available.
    assign wr_go = ev.wr_done  & w_hold & full_n;
    assign rd_go = ev.rd_begin & r_hold & empty_n;

    cfifo_token #(.EXPAND_EN(EXPAND_EN), .LEAD(LEAD)) u_wtok (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_go   (wr_go),
        .at_last (w_last),
        .grant_n (wx_in_n),
        .hold    (w_hold),
        .pass_n  (wx_out_n)
    );

    cfifo_token #(.EXPAND_EN(EXPAND_EN), .LEAD(LEAD)) u_rtok (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_go   (rd_go),
        .at_last (r_last),
        .grant_n (rx_in_n),
        .hold    (r_hold),
        .pass_n  (rx_out_n)
    );

    cfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (wr_go),
        .rd_go   (rd_go),
        .din     (din),
        .rd_word (rd_word),
        .w_last  (w_last),
        .r_last  (r_last)
    );

    cfifo_flags #(.DEPTH(DEPTH)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (wr_go),
        .rd_go   (rd_go),
        .empty_n (empty_n),
        .half_n  (half_n),
        .full_n  (full_n)
    );

    // Output stage: latch the word on a read start, release on strobe high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_oe <= 1'b0;
        end else if (rd_go) begin
            dout    <= rd_word;
            dout_oe <= 1'b1;
        end else if (ev.rd_idle) begin
            dout_oe <= 1'b0;
        end
    end

endmodule

// File: rtl/cfifo_checks.sv
// Protocol and flag checker bound to every cascade_fifo instance.
// Assumes: strobes are high during reset.
module cfifo_checks (
    input logic clk,
    input logic rst_n,
    input logic wr_n,
    input logic rd_n,
    input logic dout_oe,
    input logic empty_n,
    input logic half_n,
    input logic full_n,
    input logic wx_out_n,
    input logic rx_out_n
);

    // R7 / R8: a full buffer is also at least half full and not empty.
    p_full_implies_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> (!half_n && empty_n));

    // R6: an empty buffer stays empty unless a write strobe is released.
    p_empty_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !$rose(wr_n)) |=> !empty_n);

    // R8: a full buffer stays full unless a read starts.
    p_full_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !$fell(rd_n)) |=> !full_n);

    // R5: a read started on an empty buffer never enables the output.
    p_dry_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) && !empty_n) |=> !dout_oe);

    // R4: the output enable is released after the read strobe is high.
    p_oe_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |=> !dout_oe);

    // R11: the write hand-off pulse lasts one cycle.
    p_wpass_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wx_out_n |=> wx_out_n);

    // R12: the read hand-off pulse lasts one cycle.
    p_rpass_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_out_n |=> rx_out_n);

endmodule

bind cascade_fifo cfifo_checks u_cfifo_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_n     (wr_n),
    .rd_n     (rd_n),
    .dout_oe  (dout_oe),
    .empty_n  (empty_n),
    .half_n   (half_n),
    .full_n   (full_n),
    .wx_out_n (wx_out_n),
    .rx_out_n (rx_out_n)
);

// File: tb/cascade_fifo_bench.sv
module cascade_fifo_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Standalone device
    logic       s_wr_n = 1'b1, s_rd_n = 1'b1;
    logic [8:0] s_din = '0, s_dout;
    logic       s_oe, s_empty_n, s_half_n, s_full_n, s_wxo, s_rxo;

    // Chained pair
    logic       c_wr_n = 1'b1, c_rd_n = 1'b1;
    logic [8:0] c_din = '0, c1_dout, c2_dout;
    logic       c1_oe, c1_empty_n, c1_half_n, c1_full_n, c1_wxo, c1_rxo;
    logic       c2_oe, c2_empty_n, c2_half_n, c2_full_n, c2_wxo, c2_rxo;

    cascade_fifo #(.EXPAND_EN(1'b0), .LEAD(1'b1)) u_cascade_fifo (
        .clk(clk), .rst_n(rst_n), .wr_n(s_wr_n), .rd_n(s_rd_n), .din(s_din),
        .dout(s_dout), .dout_oe(s_oe), .empty_n(s_empty_n), .half_n(s_half_n),
        .full_n(s_full_n), .wx_in_n(1'b1), .wx_out_n(s_wxo),
        .rx_in_n(1'b1), .rx_out_n(s_rxo)
    );

    cascade_fifo #(.EXPAND_EN(1'b1), .LEAD(1'b1)) u_cascade_fifo_c1 (
        .clk(clk), .rst_n(rst_n), .wr_n(c_wr_n), .rd_n(c_rd_n), .din(c_din),
        .dout(c1_dout), .dout_oe(c1_oe), .empty_n(c1_empty_n), .half_n(c1_half_n),
        .full_n(c1_full_n), .wx_in_n(c2_wxo), .wx_out_n(c1_wxo),
        .rx_in_n(c2_rxo), .rx_out_n(c1_rxo)
    );

    cascade_fifo #(.EXPAND_EN(1'b1), .LEAD(1'b0)) u_cascade_fifo_c2 (
        .clk(clk), .rst_n(rst_n), .wr_n(c_wr_n), .rd_n(c_rd_n), .din(c_din),
        .dout(c2_dout), .dout_oe(c2_oe), .empty_n(c2_empty_n), .half_n(c2_half_n),
        .full_n(c2_full_n), .wx_in_n(c1_wxo), .wx_out_n(c2_wxo),
        .rx_in_n(c1_rxo), .rx_out_n(c2_rxo)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One write: strobe low, then released; returns at the negedge after commit.
    task automatic put(input bit ch, input logic [8:0] v);
        @(negedge clk);
        if (ch) begin c_wr_n = 1'b0; c_din = v; end
        else    begin s_wr_n = 1'b0; s_din = v; end
        @(negedge clk);
        if (ch) c_wr_n = 1'b1; else s_wr_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    // One standalone read: returns word and the enable during and after.
    task automatic take_s(output logic [8:0] d, output logic oe_on, output logic oe_off);
        @(negedge clk);
        s_rd_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        d = s_dout; oe_on = s_oe;
        s_rd_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        oe_off = s_oe;
    endtask

    // One chained read: returns both enables and the selected word.
    task automatic take_c(output logic [8:0] d, output logic oe1, output logic oe2);
        @(negedge clk);
        c_rd_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        oe1 = c1_oe; oe2 = c2_oe;
        d = c1_oe ? c1_dout : c2_dout;
        c_rd_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R2 s empty_n", s_empty_n, 0);
        chk("R2 s half_n", s_half_n, 1);
        chk("R2 s full_n", s_full_n, 1);
        chk("R2 s dout_oe", s_oe, 0);
        chk("R2 c1 empty_n", c1_empty_n, 0);
        chk("R2 c2 full_n", c2_full_n, 1);
    endtask

    task automatic t_empty_read();
        logic [8:0] d; logic on, off;
        take_s(d, on, off);
        chk("R5 empty read oe", on, 0);
        chk("R5 empty read empty_n", s_empty_n, 0);
        chk("R5 empty read half_n", s_half_n, 1);
    endtask

    task automatic t_strobe_edge();
        logic [8:0] d; logic on, off;
        @(negedge clk);
        s_wr_n = 1'b0; s_din = 9'h1A5;
        repeat (3) @(negedge clk);
        chk("R3 falling edge stores nothing", s_empty_n, 0);
        s_wr_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R6 empty_n rises after first write", s_empty_n, 1);
        take_s(d, on, off);
        chk("R1 R3 word read back", d, 9'h1A5);
        chk("R4 oe during read", on, 1);
        chk("R4 oe after release", off, 0);
        chk("R6 empty_n falls on last read", s_empty_n, 0);
    endtask

    task automatic t_simul();
        logic [8:0] d; logic on, off;
        put(1'b0, 9'h011);
        @(negedge clk);
        s_wr_n = 1'b0; s_din = 9'h022;
        @(negedge clk);
        s_wr_n = 1'b1; s_rd_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R10 simultaneous keeps empty_n", s_empty_n, 1);
        chk("R10 simultaneous read word", s_dout, 9'h011);
        s_rd_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        take_s(d, on, off);
        chk("R10 second word", d, 9'h022);
        chk("R10 empty after both", s_empty_n, 0);
    endtask

    task automatic t_fill_wrap();
        logic [8:0] d; logic on, off;
        for (int i = 0; i < 255; i++) put(1'b0, 9'(i));
        chk("R7 half_n at 255", s_half_n, 1);
        put(1'b0, 9'd255);
        chk("R7 half_n at 256", s_half_n, 0);
        for (int i = 256; i < 511; i++) put(1'b0, 9'(i));
        chk("R8 full_n at 511", s_full_n, 1);
        put(1'b0, 9'd511);
        chk("R8 full_n at 512", s_full_n, 0);
        put(1'b0, 9'h0AA);
        chk("R8 write while full ignored", s_full_n, 0);
        take_s(d, on, off);
        chk("R1 first word", d, 9'd0);
        chk("R8 full_n after read", s_full_n, 1);
        chk("R7 half_n at 511", s_half_n, 0);
        put(1'b0, 9'h155);
        chk("R9 refill after wrap", s_full_n, 0);
        for (int i = 1; i < DEPTH; i++) begin
            take_s(d, on, off);
            chk("R1 R8 drain order", d, i);
            if (i == 256) chk("R7 half_n at 256 on drain", s_half_n, 0);
            if (i == 257) chk("R7 half_n at 255 on drain", s_half_n, 1);
        end
        take_s(d, on, off);
        chk("R9 wrapped word", d, 9'h155);
        chk("R6 empty after drain", s_empty_n, 0);
    endtask

    task automatic t_chain();
        logic [8:0] d; logic o1, o2;
        for (int i = 0; i < DEPTH; i++) put(1'b1, 9'(i));
        chk("R11 pass pulse low", c1_wxo, 0);
        chk("R11 c1 full", c1_full_n, 0);
        chk("R11 c2 ignored writes without token", c2_empty_n, 0);
        @(negedge clk);
        chk("R11 pass pulse one cycle", c1_wxo, 1);
        for (int j = 0; j < 3; j++) put(1'b1, 9'(9'h100 + j));
        chk("R11 c2 accepts after grant", c2_empty_n, 1);
        for (int i = 0; i < DEPTH; i++) begin
            take_c(d, o1, o2);
            chk("R12 c1 data", d, i);
            chk("R12 c1 owns output", o1, 1);
            chk("R12 c2 silent without token", o2, 0);
        end
        chk("R12 c1 empty", c1_empty_n, 0);
        for (int j = 0; j < 3; j++) begin
            take_c(d, o1, o2);
            chk("R12 c2 data", d, 9'h100 + j);
            chk("R12 c2 owns output", o2, 1);
            chk("R12 c1 released output", o1, 0);
        end
        chk("R12 c2 empty", c2_empty_n, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_empty_read();
        t_strobe_edge();
        t_simul();
        t_fill_wrap();
        t_chain();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule